// File: doc/BRIEF.md
# Half-Step Fractional Tick Divider

This block turns a stream of single-cycle source ticks into a slower stream of single-cycle output ticks. All ticks live in one system clock domain. A 32-bit control word selects which of up to eight source tick inputs is used. It also sets a divisor with one fractional bit, so the average ratio between source ticks and output ticks is (D+2)/2. The ratio can therefore be a whole number or a whole number plus one half. A power-of-two post-divider, with an exponent from 0 to 8, then thins the result further.

The first stage is an accumulator. Each selected source tick adds two to it. When the sum reaches D+2, the limit is subtracted and a first-stage tick is produced. Output spacing therefore alternates between the two nearest whole numbers of source ticks.

Reconfiguration is ordered:
- A new divisor is taken up only at a first-stage tick or while the accumulator is empty. No output interval is ever cut short or merged with the next one.
- A new source selection waits a fixed settle interval of clock cycles before it is used.

A hold input keeps the divider quiet and empties its counters.

Top module: `halfstep_tick_div`

## Requirements
- R1: A synchronous reset sets the control word to zero (source 0, divisor 0, post-divide exponent 0), empties the accumulator and post counter, and drives `tick_out` low.
- R2: With divisor field 0 and exponent 0, every tick on the selected source gives exactly one `tick_out` pulse, one clock cycle later.
- R3: Starting from an empty accumulator with exponent 0, N·(D+2) selected source ticks give exactly 2·N output ticks. This holds up to the largest divisor code.
- R4: With a constant divisor and a steady source, the number of source ticks between consecutive output ticks is always floor or ceil of (D+2)/2.
- R5: The divisor is bits [DIV_W-1:0] of the control word (DIV_W is 8 or 16). Bits between DIV_W and 23 have no effect on the ratio.
- R6: The source code is read from bits [31:30] (2 bits), [31:29] (3 bits, default) or [29:28] (2 bits), chosen by a parameter. A code at or above the number of connected sources produces no output ticks.
- R7: The exponent k is bits [27:24]. Each output tick is one of every 2^k first-stage ticks. Codes above 8 act as 8.
- R8: A divisor written while the accumulator holds a partial count takes effect only after the next first-stage tick. A divisor written while the accumulator is empty takes effect at once.
- R9: After a write that changes the source code, the previous source stays in use for SETTLE clock cycles. The new source is used from the cycle after that.
- R10: While `hold` is high, `tick_out` stays low and the accumulator and post counter are emptied. After release, counting restarts from zero.
- R11: `ctrl_rd` returns the last control word written, from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| hold | input | 1 | Keeps the divider quiet and its counters empty |
| src_tick | input | NUM_SRC | Single-cycle tick inputs, one per source |
| wr_en | input | 1 | Writes `wr_data` into the control word |
| wr_data | input | 32 | New control word |
| ctrl_rd | output | 32 | Current control word |
| tick_out | output | 1 | Divided single-cycle tick strobe |

## Verification
The divider is exercised with three source patterns:
- Back-to-back source ticks measure output spacing cycle by cycle, which separates a true half-step alternation from a rounded whole ratio.
- Sparse ticks with idle gaps show that only ticks advance the accumulator, not clock cycles.
- Tick bursts on unselected or unconnected inputs show that the selector rejects them.

Reconfiguration is tested by writing a new divisor partway through a count and a new source code while the old source keeps ticking. The output counts then reveal whether the divisor change waited for a tick boundary and whether the source change waited out the settle window. A reference model runs alongside every clock, so any slip by one cycle in these hand-overs shows up as a miscompare.

// File: rtl/hsd_pkg.sv
package hsd_pkg;

    typedef enum int {
        SEL_HI2  = 0,
        SEL_HI3  = 1,
        SEL_MID2 = 2
    } sel_layout_e;

    localparam int POST_LSB  = 24;
    localparam int POST_FW   = 4;
    localparam int POST_KMAX = 8;

    function automatic int sel_width(sel_layout_e lay);
        return (lay == SEL_HI3) ? 3 : 2;
    endfunction

    function automatic int sel_lsb(sel_layout_e lay);
        case (lay)
            SEL_HI2: return 30;
            SEL_HI3: return 29;
            default: return 28;
        endcase
    endfunction

endpackage

// File: rtl/hsd_ctrl.sv
module hsd_ctrl #(
    parameter hsd_pkg::sel_layout_e SEL_LAYOUT = hsd_pkg::SEL_HI3,
    parameter int NUM_SRC = 6,
    parameter int DIV_W   = 8,
    parameter int SETTLE  = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [31:0]        wr_data,
    input  logic [NUM_SRC-1:0] src_tick,
    output logic [31:0]        ctrl_o,
    output logic [DIV_W-1:0]   div_new_o,
    output logic [3:0]         post_k_o,
    output logic               sel_tick_o
);
    localparam int SEL_W = hsd_pkg::sel_width(SEL_LAYOUT);
    localparam int SEL_L = hsd_pkg::sel_lsb(SEL_LAYOUT);
    localparam int CNT_W = $clog2(SETTLE + 1);

    typedef struct packed {
        logic [31:0]      word;
        logic [SEL_W-1:0] sel;
        logic [CNT_W-1:0] settle;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic [SEL_W-1:0] sel_field;
    logic [3:0]       k_raw;

    always_comb begin
        sel_field = st_q.word[SEL_L +: SEL_W];
        k_raw     = st_q.word[hsd_pkg::POST_LSB +: hsd_pkg::POST_FW];
        st_d      = st_q;

        if (st_q.settle != '0) begin
            st_d.settle = st_q.settle - 1'b1;
            if (st_q.settle == CNT_W'(1)) begin
                st_d.sel = sel_field;
            end
        end

        if (wr_en) begin
            st_d.word = wr_data;
            if (wr_data[SEL_L +: SEL_W] != sel_field) begin
                st_d.settle = CNT_W'(SETTLE);
            end
        end

        sel_tick_o = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (int'(st_q.sel) == i) begin
                sel_tick_o = src_tick[i];
            end
        end

        div_new_o = st_q.word[DIV_W-1:0];
        post_k_o  = (k_raw > 4'(hsd_pkg::POST_KMAX)) ? 4'(hsd_pkg::POST_KMAX) : k_raw;
        ctrl_o    = st_q.word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R9
    sel_settle_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(st_q.sel)) |-> ($past(st_q.settle) == CNT_W'(1)));

    // R11
    word_load_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en)) |-> (st_q.word == $past(wr_data)));

endmodule

// File: rtl/hsd_accum.sv
module hsd_accum #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic             tick_i,
    input  logic [DIV_W-1:0] div_new_i,
    output logic             stage_o
);
    localparam int ACC_W = DIV_W + 2;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [DIV_W-1:0] div_act;
    } acc_st_t;

    acc_st_t          st_d, st_q;
    logic [ACC_W-1:0] lim;
    logic [ACC_W-1:0] sum;
    logic             empty;

    always_comb begin
        empty   = (st_q.acc == '0);
        lim     = (empty ? ACC_W'(div_new_i) : ACC_W'(st_q.div_act)) + ACC_W'(2);
        sum     = st_q.acc + ACC_W'(2);
        st_d    = st_q;
        stage_o = 1'b0;

        if (hold) begin
            st_d.acc     = '0;
            st_d.div_act = div_new_i;
        end else begin
            if (empty) begin
                st_d.div_act = div_new_i;
            end
            if (tick_i) begin
                if (sum >= lim) begin
                    st_d.acc     = sum - lim;
                    st_d.div_act = div_new_i;
                    stage_o      = 1'b1;
                end else begin
                    st_d.acc = sum;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R4
    acc_bound_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.acc < (ACC_W'(st_q.div_act) + ACC_W'(2)));

    // R8
    div_swap_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(st_q.div_act)) |->
            $past(hold || empty || stage_o));

endmodule

// File: rtl/hsd_post.sv
module hsd_post #(
    parameter int KMAX = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       hold,
    input  logic       stage_i,
    input  logic [3:0] k_i,
    output logic       tick_o
);
    localparam int CNT_W = KMAX;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tick;
    } post_st_t;

    post_st_t       st_d, st_q;
    logic [CNT_W:0] last;

    always_comb begin
        last      = ((CNT_W+1)'(1) << k_i) - (CNT_W+1)'(1);
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (hold) begin
            st_d.cnt = '0;
        end else if (stage_i) begin
            if ({1'b0, st_q.cnt} >= last) begin
                st_d.cnt  = '0;
                st_d.tick = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        tick_o = st_q.tick;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R7
    post_src_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.tick |-> $past(stage_i));

endmodule

// File: rtl/halfstep_tick_div.sv
module halfstep_tick_div #(
    parameter hsd_pkg::sel_layout_e SEL_LAYOUT = hsd_pkg::SEL_HI3,
    parameter int NUM_SRC = 6,
    parameter int DIV_W   = 8,
    parameter int SETTLE  = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hold,
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic               wr_en,
    input  logic [31:0]        wr_data,
    output logic [31:0]        ctrl_rd,
    output logic               tick_out
);
    logic [DIV_W-1:0] div_new;
    logic [3:0]       post_k;
    logic             sel_tick;
    logic             stage;

    hsd_ctrl #(
        .SEL_LAYOUT (SEL_LAYOUT),
        .NUM_SRC    (NUM_SRC),
        .DIV_W      (DIV_W),
        .SETTLE     (SETTLE)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .src_tick   (src_tick),
        .ctrl_o     (ctrl_rd),
        .div_new_o  (div_new),
        .post_k_o   (post_k),
        .sel_tick_o (sel_tick)
    );

    hsd_accum #(
        .DIV_W     (DIV_W)
    ) u_accum (
        .clk       (clk),
        .rst       (rst),
        .hold      (hold),
        .tick_i    (sel_tick),
        .div_new_i (div_new),
        .stage_o   (stage)
    );

    hsd_post #(
        .KMAX    (hsd_pkg::POST_KMAX)
    ) u_post (
        .clk     (clk),
        .rst     (rst),
        .hold    (hold),
        .stage_i (stage),
        .k_i     (post_k),
        .tick_o  (tick_out)
    );

    // R10
    hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(hold) |-> !tick_out);

    // R2
    tick_src_chk: assert property (@(posedge clk) disable iff (rst)
        tick_out |-> $past(sel_tick));

endmodule

// File: tb/sim_halfstep_tick_div.sv
module sim_halfstep_tick_div;
    localparam hsd_pkg::sel_layout_e LAY = hsd_pkg::SEL_HI3;
    localparam int NS     = 6;
    localparam int DW     = 8;
    localparam int SETTLE = 3;
    localparam int SL     = hsd_pkg::sel_lsb(LAY);
    localparam int SMASK  = (1 << hsd_pkg::sel_width(LAY)) - 1;
    localparam int DMASK  = (1 << DW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          hold = 1'b0;
    logic [NS-1:0] src_tick = '0;
    logic          wr_en = 1'b0;
    logic [31:0]   wr_data = '0;
    logic [31:0]   ctrl_rd;
    logic          tick_out;

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;
    string cur_req = "R1";

    halfstep_tick_div #(.SEL_LAYOUT(LAY), .NUM_SRC(NS), .DIV_W(DW), .SETTLE(SETTLE)) u0 (
        .clk(clk), .rst(rst), .hold(hold), .src_tick(src_tick),
        .wr_en(wr_en), .wr_data(wr_data), .ctrl_rd(ctrl_rd), .tick_out(tick_out)
    );

    always #5 clk = ~clk;

    // behavioural reference
    logic [31:0] m_ctrl = '0;
    int  m_acc = 0, m_dact = 0, m_sact = 0, m_settle = 0, m_pc = 0;
    bit  m_tick = 0;
    bit  m_live = 0;

    always @(posedge clk) begin
        int dnew, selold, k, lim, sum;
        bit tin, st;
        m_live <= 1'b1;
        if (rst) begin
            m_ctrl = '0; m_acc = 0; m_dact = 0; m_sact = 0;
            m_settle = 0; m_pc = 0; m_tick = 0;
        end else begin
            dnew   = int'(m_ctrl) & DMASK;
            selold = int'(m_ctrl >> SL) & SMASK;
            k      = int'(m_ctrl >> 24) & 15;
            if (k > 8) k = 8;
            tin = (m_sact < NS) ? src_tick[m_sact] : 1'b0;
            st  = 0;
            if (hold) begin
                m_acc = 0; m_pc = 0; m_dact = dnew;
            end else begin
                lim = ((m_acc == 0) ? dnew : m_dact) + 2;
                if (m_acc == 0) m_dact = dnew;
                if (tin) begin
                    sum = m_acc + 2;
                    if (sum >= lim) begin
                        m_acc = sum - lim; m_dact = dnew; st = 1;
                    end else m_acc = sum;
                end
            end
            m_tick = 0;
            if (st) begin
                if (m_pc >= (1 << k) - 1) begin m_tick = 1; m_pc = 0; end
                else m_pc++;
            end
            if (m_settle != 0) begin
                if (m_settle == 1) m_sact = selold;
                m_settle--;
            end
            if (wr_en) begin
                if ((int'(wr_data >> SL) & SMASK) != selold) m_settle = SETTLE;
                m_ctrl = wr_data;
            end
        end
    end

    // per-cycle compare and output monitors
    int out_cnt = 0;
    int gap_cnt = 0, gmin = 1000, gmax = 0;
    bit gseen = 0;

    always @(negedge clk) begin
        if (m_live) begin
            vectors++;
            if (tick_out !== m_tick || ctrl_rd !== m_ctrl) begin
                fails++;
                $display("FAIL %s: tick_out=%0b ctrl_rd=%h expected tick_out=%0b ctrl_rd=%h",
                         cur_req, tick_out, ctrl_rd, m_tick, m_ctrl);
            end
        end
        if (tick_out === 1'b1) begin
            out_cnt++;
            if (gseen) begin
                if (gap_cnt < gmin) gmin = gap_cnt;
                if (gap_cnt > gmax) gmax = gap_cnt;
            end
            gseen = 1; gap_cnt = 1;
        end else gap_cnt++;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            fails++;
            $display("FAIL watchdog: cycles=%0d expected completion before %0d", cycles, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic check(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); src_tick = '0; wr_en = 1'b0; hold = 1'b0;
        end
    endtask

    task automatic write_ctrl(logic [31:0] w);
        @(negedge clk); wr_en = 1'b1; wr_data = w; src_tick = '0;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic clear_hold();
        @(negedge clk); hold = 1'b1; src_tick = '0;
        @(negedge clk); hold = 1'b0;
        idle(2);
        out_cnt = 0;
    endtask

    task automatic feed(logic [NS-1:0] pat, int n, int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); src_tick = pat;
            for (int g = 0; g < gap; g++) begin
                @(negedge clk); src_tick = '0;
            end
        end
        @(negedge clk); src_tick = '0;
        idle(3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 ctrl_rd", int'(ctrl_rd), 0);
        check("R1 tick_out", int'(tick_out), 0);
        @(negedge clk); rst = 1'b0;
        idle(2);

        // R2 pass-through
        cur_req = "R2";
        write_ctrl(32'h0000_0000); clear_hold();
        feed(6'b000001, 10, 0);
        check("R2 pass-through count", out_cnt, 10);
        out_cnt = 0; feed(6'b000001, 7, 2);
        check("R2 sparse pass-through", out_cnt, 7);

        // R3 half-step ratios
        cur_req = "R3";
        write_ctrl(32'h0000_0001); clear_hold();
        feed(6'b000001, 30, 1);
        check("R3 ratio 1.5", out_cnt, 20);
        write_ctrl(32'h0000_0003); clear_hold();
        feed(6'b000001, 25, 0);
        check("R3 ratio 2.5", out_cnt, 10);
        write_ctrl(32'h0000_00FE); clear_hold();
        feed(6'b000001, 256, 0);
        check("R3 ratio 128 max code", out_cnt, 2);

        // R4 spacing
        cur_req = "R4";
        write_ctrl(32'h0000_0005); clear_hold();
        gseen = 0; gmin = 1000; gmax = 0;
        feed(6'b000001, 70, 0);
        check("R4 min spacing", gmin, 3);
        check("R4 max spacing", gmax, 4);

        // R5 bits above the divisor field ignored
        cur_req = "R5";
        write_ctrl(32'h0000_0101); clear_hold();
        feed(6'b000001, 30, 0);
        check("R5 upper bits ignored", out_cnt, 20);

        // R11 readback
        cur_req = "R11";
        write_ctrl(32'h00A5_3C01); idle(1);
        check("R11 readback", int'(ctrl_rd), int'(32'h00A5_3C01));

        // R7 post-divider
        cur_req = "R7";
        write_ctrl(32'h0200_0000); clear_hold();
        feed(6'b000001, 16, 0);
        check("R7 k=2", out_cnt, 4);
        write_ctrl(32'h0C00_0000); clear_hold();
        feed(6'b000001, 512, 0);
        check("R7 k=12 clamps to 8", out_cnt, 2);

        // R8 divisor applied at tick boundary
        cur_req = "R8";
        write_ctrl(32'h0000_0009); clear_hold();
        feed(6'b000001, 3, 0);
        check("R8 partial count no output", out_cnt, 0);
        write_ctrl(32'h0000_0000); out_cnt = 0;
        feed(6'b000001, 3, 0);
        check("R8 old divisor finishes interval", out_cnt, 1);
        out_cnt = 0; feed(6'b000001, 4, 0);
        check("R8 new divisor after boundary", out_cnt, 4);

        // R10 hold
        cur_req = "R10";
        write_ctrl(32'h0000_0001); clear_hold();
        feed(6'b000001, 1, 0);
        @(negedge clk); hold = 1'b1; src_tick = 6'b000001;
        @(negedge clk); @(negedge clk);
        @(negedge clk); hold = 1'b0; src_tick = '0;
        idle(3);
        check("R10 quiet under hold", out_cnt, 0);
        feed(6'b000001, 1, 0);
        check("R10 accumulator cleared", out_cnt, 0);
        feed(6'b000001, 1, 0);
        check("R10 restart from zero", out_cnt, 1);

        // R6 unconnected code and valid high code
        cur_req = "R6";
        write_ctrl(32'hC000_0000); clear_hold(); idle(SETTLE + 2); out_cnt = 0;
        feed(6'b111111, 10, 0);
        check("R6 code 6 unconnected", out_cnt, 0);
        write_ctrl(32'hA000_0000); clear_hold(); idle(SETTLE + 2); out_cnt = 0;
        feed(6'b011111, 6, 0);
        check("R6 code 5 rejects others", out_cnt, 0);
        feed(6'b100000, 6, 0);
        check("R6 code 5 selects input 5", out_cnt, 6);

        // R9 settle window
        cur_req = "R9";
        write_ctrl(32'h0000_0000); idle(SETTLE + 2); clear_hold();
        @(negedge clk); wr_en = 1'b1; wr_data = 32'h2000_0000; src_tick = '0;
        for (int i = 0; i < SETTLE + 4; i++) begin
            @(negedge clk); wr_en = 1'b0; src_tick = 6'b000001;
        end
        @(negedge clk); src_tick = '0;
        idle(3);
        check("R9 old source during settle", out_cnt, SETTLE);
        out_cnt = 0; feed(6'b000010, 4, 0);
        check("R9 new source after settle", out_cnt, 4);

        idle(2);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule